// File: doc/BRIEF.md
# One-Shot Event Timer with Free-Running Timebase

The block is a small memory-mapped timer unit with two independent counters. A down-counter delivers one-shot delays: software programs a reload value, moves the counter into load and then into run through an operation field in the control register, and the counter decrements once per clock until it reaches zero. At zero it raises a status flag and stays at zero; it does not reload on its own. A hold operation freezes the counter at any time.

Next to it, an up-counter counts every clock from reset and wraps at its width, so it can serve as a timebase. The expiry status passes through a one-bit enable mask to the interrupt output. Software clears the status by writing one to an acknowledge register. Reads go through a simple select/write-enable/address port, and read data appears one clock after the request.

Register word addresses: 0 reload value, 1 control, 2 live count, 3 timebase, 4 mask, 5 masked status, 6 acknowledge (write only, reads 0), 7 raw status. Control layout: bits [1:0] are the operation (0 hold, 1 load, 2 run, 3 behaves as hold), and bits [3:2] are the rate select (0 means count on every clock).

Top module: `evt_timer_unit`

## Requirements
- R1: After reset, control reads 0 (operation hold), mask reads 0, live count reads 0, raw status reads 0 and `irq_o` is low.
- R2: The timebase at address 3 increments by one on every clock edge after reset is released and wraps to 0 after 2^TIME_W counts.
- R3: The reload value at address 0 reads back as written. While the operation is load, the live count at address 2 takes the reload value on each clock, and this works for values up to 0xFFFFFFFF.
- R4: While the operation is run and the rate select is 0, the live count drops by one per clock, and it reads back at address 2.
- R5: When a running count steps from 1 to 0, raw status bit 0 sets on that same edge. The count then stays at 0 and raises no further status.
- R6: The hold operation freezes the live count. Neither hold nor any clock edge without an acknowledge clears a pending status.
- R7: `irq_o` and bit 0 of the masked status at address 5 equal raw status bit 0 AND mask bit 0.
- R8: Writing 1 to bit 0 of address 6 clears raw status bit 0 at the next edge. Writing 0 leaves it unchanged.
- R9: With the run operation and a nonzero rate select, the live count does not move, and the control register reads back the written select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one count per edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid the clock after a read request |
| irq_o | output | 1 | Masked expiry interrupt |

## Verification
A count that moves on the wrong edge shows up at the live-count port as a value off by one. That error is visible one read after the next hold. A misplaced expiry shows as `irq_o` rising one clock early or late relative to the run write, so the bench samples the interrupt on the exact clock before and after the expected edge. A status flag that is lost, or that re-arms at zero, changes `irq_o` within one clock after a hold, an acknowledge or an idle stretch. A timebase with a skipped or extra step gives a wrong value on every later read, including the read taken after the wrap.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_RUN  = 2'd2,
    OP_RSVD = 2'd3
  } op_e;

  localparam int unsigned FSEL_W    = 2;
  localparam logic [FSEL_W-1:0] FSEL_FULL = '0;

  localparam int unsigned REG_DIV    = 0;
  localparam int unsigned REG_CTRL   = 1;
  localparam int unsigned REG_CNT    = 2;
  localparam int unsigned REG_TIME   = 3;
  localparam int unsigned REG_MASK   = 4;
  localparam int unsigned REG_MASKED = 5;
  localparam int unsigned REG_ACK    = 6;
  localparam int unsigned REG_RAW    = 7;
endpackage

// File: rtl/oneshot_counter.sv
module oneshot_counter
  import evt_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  op_e              op_i,
  input  logic             tick_en_i,
  input  logic [CNT_W-1:0] div_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_en;

  assign run_en   = (op_i == OP_RUN) && tick_en_i;
  assign expire_o = run_en && (cnt_q == CNT_W'(1));
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case (op_i)
        OP_LOAD: cnt_q <= div_i;
        OP_RUN:  if (run_en && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/timebase_counter.sv
module timebase_counter #(
  parameter int unsigned TIME_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [TIME_W-1:0] time_o
);
  logic [TIME_W-1:0] time_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) time_q <= '0;
    else         time_q <= time_q + TIME_W'(1);
  end

  assign time_o = time_q;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int unsigned N_SRC = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] ack_i,
  input  logic [N_SRC-1:0] mask_i,
  output logic [N_SRC-1:0] raw_o,
  output logic [N_SRC-1:0] masked_o
);
  logic [N_SRC-1:0] raw_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    // a new expiry wins over an acknowledge in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       raw_q[i] <= 1'b0;
      else if (set_i[i]) raw_q[i] <= 1'b1;
      else if (ack_i[i]) raw_q[i] <= 1'b0;
    end
  end

  assign raw_o    = raw_q;
  assign masked_o = raw_q & mask_i;
endmodule

// File: rtl/evt_timer_unit.sv
module evt_timer_unit
  import evt_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned TIME_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned N_SRC  = 1;
  localparam int unsigned CTRL_W = 2 + FSEL_W;

  logic [CNT_W-1:0]  div_q;
  op_e               op_q;
  logic [FSEL_W-1:0] fsel_q;
  logic [N_SRC-1:0]  mask_q;
  logic [DATA_W-1:0] rdata_q;

  logic [CNT_W-1:0]  cnt;
  logic [TIME_W-1:0] tb;
  logic              expire;
  logic [N_SRC-1:0]  raw, masked, ack;
  logic              wr_en, rd_en;

  assign wr_en = sel_i && we_i;
  assign rd_en = sel_i && !we_i;
  assign ack   = (wr_en && addr_i == ADDR_W'(REG_ACK)) ? wdata_i[N_SRC-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      op_q   <= OP_HOLD;
      fsel_q <= FSEL_FULL;
      mask_q <= '0;
    end else if (wr_en) begin
      if (addr_i == ADDR_W'(REG_DIV))  div_q <= wdata_i[CNT_W-1:0];
      if (addr_i == ADDR_W'(REG_CTRL)) begin
        op_q   <= op_e'(wdata_i[1:0]);
        fsel_q <= wdata_i[CTRL_W-1:2];
      end
      if (addr_i == ADDR_W'(REG_MASK)) mask_q <= wdata_i[N_SRC-1:0];
    end
  end

  oneshot_counter #(.CNT_W(CNT_W)) i_oneshot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op_q),
    .tick_en_i (fsel_q == FSEL_FULL),
    .div_i     (div_q),
    .cnt_o     (cnt),
    .expire_o  (expire)
  );

  timebase_counter #(.TIME_W(TIME_W)) i_timebase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .time_o (tb)
  );

  irq_ctrl #(.N_SRC(N_SRC)) i_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (expire),
    .ack_i    (ack),
    .mask_i   (mask_q),
    .raw_o    (raw),
    .masked_o (masked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      unique case (addr_i)
        ADDR_W'(REG_DIV):    rdata_q <= DATA_W'(div_q);
        ADDR_W'(REG_CTRL):   rdata_q <= DATA_W'({fsel_q, op_q});
        ADDR_W'(REG_CNT):    rdata_q <= DATA_W'(cnt);
        ADDR_W'(REG_TIME):   rdata_q <= DATA_W'(tb);
        ADDR_W'(REG_MASK):   rdata_q <= DATA_W'(mask_q);
        ADDR_W'(REG_MASKED): rdata_q <= DATA_W'(masked);
        ADDR_W'(REG_RAW):    rdata_q <= DATA_W'(raw);
        default:             rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = masked[0];
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
  import evt_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned TIME_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [1:0]        op_q,
  input logic [FSEL_W-1:0] fsel_q,
  input logic [CNT_W-1:0]  div_q,
  input logic [CNT_W-1:0]  cnt,
  input logic [TIME_W-1:0] tb,
  input logic              expire,
  input logic [0:0]        raw
);
  logic ack_wr;
  assign ack_wr = sel_i && we_i && addr_i == ADDR_W'(REG_ACK) && wdata_i[0];

  p_time_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> tb == $past(tb) + TIME_W'(1));

  p_load_copy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_q == 2'(OP_LOAD) |=> cnt == $past(div_q));

  p_run_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == 2'(OP_RUN) && fsel_q == FSEL_FULL && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1));

  p_zero_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == 2'(OP_RUN) && fsel_q == FSEL_FULL && cnt == CNT_W'(1)) |=> raw[0]);

  p_stay_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0 && op_q != 2'(OP_LOAD)) |=> cnt == '0);

  p_no_refire_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0) |-> !expire);

  p_hold_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == 2'(OP_HOLD)) |=> $stable(cnt));

  p_raw_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw[0] && !ack_wr) |=> raw[0]);

  p_ack_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_wr && !expire) |=> !raw[0]);

  p_fsel_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == 2'(OP_RUN) && fsel_q != FSEL_FULL) |=> $stable(cnt));
endmodule

bind evt_timer_unit evt_timer_chk #(
  .CNT_W(CNT_W), .TIME_W(TIME_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sel_i   (sel_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .op_q    (op_q),
  .fsel_q  (fsel_q),
  .div_q   (div_q),
  .cnt     (cnt),
  .tb      (tb),
  .expire  (expire),
  .raw     (raw)
);

// File: tb/test_evt_timer_unit.sv
module test_evt_timer_unit;
  localparam int unsigned TW = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0, errors = 0;
  int unsigned edges = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  logic issued = 1'b0;

  evt_timer_unit #(.TIME_W(TW)) i_evt_timer_unit (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst_n) edges <= edges + 1;
    issued <= sel && !we;
  end

  // monitor: compare captured read data against queued expectation
  always @(negedge clk) begin
    #2;
    if (issued) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (rdata !== it.exp) begin
        errors++;
        $display("FAIL %s: read got %h expected %h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: irq_o got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    sel = 1; we = 1; addr = 3'(a); wdata = d;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag, input bit is_time = 0);
    item_t it;
    @(negedge clk);
    sel = 1; we = 0; addr = 3'(a);
    it.exp = is_time ? 32'(edges % (1 << TW)) : e;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sel = 0; we = 0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(irq, 1'b0, "R1 reset irq");
    rd(1, 32'h0, "R1 ctrl");
    rd(4, 32'h0, "R1 mask");
    rd(2, 32'h0, "R1 count");
    rd(7, 32'h0, "R1 raw");
    rd(3, 0, "R2 time after reset", 1);

    // load and run
    wr(0, 32'd100);
    rd(0, 32'd100, "R3 reload readback");
    wr(1, 32'd1);
    idle(1);
    rd(2, 32'd100, "R3 count loaded");
    wr(1, 32'd2);
    idle(4);
    wr(1, 32'd0);
    rd(2, 32'd95, "R4 five decrements");
    idle(3);
    rd(2, 32'd95, "R6 hold freezes");

    // nonzero rate select stalls counting
    wr(1, 32'h6);
    rd(1, 32'h6, "R9 ctrl readback");
    idle(5);
    wr(1, 32'd0);
    rd(2, 32'd95, "R9 count stalled");

    // minimum delay expiry with mask enabled
    wr(4, 32'd1);
    wr(0, 32'd2);
    wr(1, 32'd1);
    wr(1, 32'd2);
    idle(1); chk(irq, 1'b0, "R5 not yet (1)");
    idle(1); chk(irq, 1'b0, "R5 not yet (2)");
    idle(1); chk(irq, 1'b1, "R5 fires after 2 ticks");
    rd(2, 32'd0, "R5 count at zero");
    rd(7, 32'd1, "R5 raw set");
    rd(5, 32'd1, "R7 masked set");
    idle(5);
    rd(2, 32'd0, "R5 stays zero");

    wr(1, 32'd0);
    idle(2); chk(irq, 1'b1, "R6 hold keeps pending");
    wr(6, 32'd0);
    idle(1); chk(irq, 1'b1, "R8 ack of zero ignored");
    wr(6, 32'd1);
    idle(1); chk(irq, 1'b0, "R8 ack clears");
    rd(7, 32'd0, "R8 raw cleared");

    // expiry with mask disabled
    wr(4, 32'd0);
    wr(0, 32'd3);
    wr(1, 32'd1);
    wr(1, 32'd2);
    idle(6); chk(irq, 1'b0, "R7 masked off");
    rd(7, 32'd1, "R7 raw set under mask");
    rd(5, 32'd0, "R7 masked reads zero");
    wr(4, 32'd1);
    idle(1); chk(irq, 1'b1, "R7 unmask raises irq");
    wr(6, 32'd1);
    idle(6); chk(irq, 1'b0, "R5 no refire at zero");

    // largest reload value
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'd1);
    wr(1, 32'd2);
    idle(2);
    wr(1, 32'd0);
    rd(2, 32'hFFFF_FFFC, "R3 R4 max reload");

    // timebase wrap
    while (edges < 1100) idle(1);
    rd(3, 0, "R2 time after wrap", 1);
    rd(3, 0, "R2 time next step", 1);

    idle(4);
    finish_run();
  end
endmodule